// File: doc/BRIEF.md
# SDRAM Line Burst-Write Sequencer

This block writes one 32-byte line into a 32-bit synchronous DRAM as a single burst of eight beats. A line-write request, such as a cache line being evicted or a 32-byte block move, arrives as a one-cycle start pulse. The pulse carries the bank, the row, the starting column and the whole line held as eight data words. The sequencer opens the row, waits a programmable number of row-to-column cycles, and then issues one write command. Auto-precharge is always requested with that write. The eight words follow on consecutive cycles.

The starting column does not have to be line-aligned. The beats then wrap around inside the aligned eight-word line, so each beat carries the word whose line offset matches its column. After the last beat the sequencer holds the bank for a programmable write-recovery count and one precharge-wait cycle. It then drops busy and pulses done. All timing settings are taken at the start pulse. Any start that arrives while a burst is running is dropped.

Top module: `sdram_line_writer`

## Requirements
- R1: In the first cycle after a start is accepted, the command pins {cs_n, ras_n, cas_n, we_n} read 0011 (activate), ba_o carries the requested bank and addr_o carries the requested row.
- R2: Between the activate cycle and the write cycle there are exactly trw_cfg_i NOP cycles (0 to 3), using the value sampled with the start pulse.
- R3: The write command reads 0100 on {cs_n, ras_n, cas_n, we_n}. During it, ba_o carries the bank, addr_o[9:0] carries the start column, addr_o[10] is 1 (auto-precharge) and all other addr_o bits are 0.
- R4: Eight data beats run on consecutive cycles, the first in the write cycle. dqm_o is 0000 during these beats and 1111 in every other cycle. dq_o is 0 outside the beats.
- R5: Beat i (i = 0..7) drives line word ((col[2:0] + i) mod 8), where word k is line_i[32k+31:32k]. The order therefore wraps inside the aligned line.
- R6: After the last beat there are exactly trwl_cfg_i write-recovery NOP cycles (0 to 7), using the value sampled with the start pulse, followed by one precharge-wait NOP cycle.
- R7: busy_o is high from the activate cycle through the precharge-wait cycle. done_o is high for exactly the one cycle after the precharge-wait cycle, and in that cycle busy_o is low.
- R8: A start pulse that arrives while busy_o is high is ignored. The running burst keeps its bank, row, column, data and timing.
- R9: After reset, busy_o and done_o are 0, the pins read NOP (0111), dqm_o is 1111, and ba_o, addr_o and dq_o are 0.
- R10: Every cycle that is neither the activate cycle nor the write cycle drives NOP (0111), with ba_o and addr_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle line-write request |
| bank_i | input | 2 | Target bank |
| row_i | input | 13 | Row address |
| col_i | input | 10 | Starting column, in 32-bit words |
| line_i | input | 256 | Line data, word k at bits 32k+31:32k |
| trw_cfg_i | input | 2 | Row-to-column wait cycles |
| trwl_cfg_i | input | 3 | Write-recovery cycles |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Multiplexed row/column address |
| dqm_o | output | 4 | Byte masks, high = masked |
| dq_o | output | 32 | Write data |

## Verification
The bench builds the block with its default widths: 2 bank bits, 13 row bits, 10 column bits and 32-bit data. With these widths the full timing space is small, so the bench runs every combination of row-to-column wait and write-recovery count (32 bursts). It also runs all eight sub-line starting offsets to exercise the wrap order. Every pin is compared in every cycle of each burst against a cycle schedule computed from the two counts. Extra bursts inject a second start mid-burst, and change the inputs right after the accepted start, to show that neither one reaches the pins.

// File: rtl/slw_pkg.sv
package slw_pkg;
  localparam int BEATS = 8;
  localparam int IDX_W = $clog2(BEATS);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ACT, PH_TRW, PH_BEAT, PH_RECOV, PH_TPC
  } phase_t;

  typedef enum logic [3:0] {
    CMD_ACTV  = 4'b0011,
    CMD_WRITE = 4'b0100,
    CMD_NOP   = 4'b0111
  } cmd_t;

  // Line word carried by a beat: offset wraps inside the aligned line.
  function automatic logic [IDX_W-1:0] wrap_idx(input logic [IDX_W-1:0] base,
                                                input logic [IDX_W-1:0] beat);
    return base + beat;
  endfunction

  // True when a counter value is the final one of a run of 'lim' cycles.
  function automatic logic at_limit(input logic [IDX_W-1:0] c,
                                    input logic [IDX_W:0]   lim);
    return ({1'b0, c} + 1'b1) == lim;
  endfunction
endpackage

// File: rtl/slw_req_hold.sv
module slw_req_hold #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [1:0]        trw_i,
  input  logic [2:0]        trwl_i,
  output logic [BANK_W-1:0] bank_q,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic [LINE_W-1:0] line_q,
  output logic [1:0]        trw_q,
  output logic [2:0]        trwl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      line_q <= '0;
      trw_q  <= '0;
      trwl_q <= '0;
    end else if (load) begin
      bank_q <= bank_i;
      row_q  <= row_i;
      col_q  <= col_i;
      line_q <= line_i;
      trw_q  <= trw_i;
      trwl_q <= trwl_i;
    end
  end

  // R8: a start during a busy burst must not disturb the held request
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && start_i) |=> ($stable(bank_q) && $stable(row_q) && $stable(col_q)
                             && $stable(trw_q) && $stable(trwl_q)));
endmodule

// File: rtl/slw_phase_fsm.sv
module slw_phase_fsm
  import slw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       trw_q,
  input  logic [2:0]       trwl_q,
  output phase_t           phase,
  output logic [IDX_W-1:0] cnt,
  output logic             done
);
  logic [IDX_W:0] trw_lim;
  logic [IDX_W:0] trwl_lim;
  logic           beat_last;

  assign trw_lim   = {{(IDX_W-1){1'b0}}, trw_q};
  assign trwl_lim  = {1'b0, trwl_q};
  assign beat_last = at_limit(cnt, (IDX_W+1)'(BEATS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase <= PH_ACT;
          cnt   <= '0;
        end
        PH_ACT: begin
          cnt   <= '0;
          phase <= (trw_q == 2'd0) ? PH_BEAT : PH_TRW;
        end
        PH_TRW: begin
          if (at_limit(cnt, trw_lim)) begin
            phase <= PH_BEAT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_BEAT: begin
          if (beat_last) begin
            cnt   <= '0;
            phase <= (trwl_q == 3'd0) ? PH_TPC : PH_RECOV;
          end else cnt <= cnt + 1'b1;
        end
        PH_RECOV: begin
          if (at_limit(cnt, trwl_lim)) begin
            phase <= PH_TPC;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_TPC: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4: a burst leaves the beat phase right after its eighth beat
  a_r4_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BEAT && cnt == IDX_W'(BEATS-1)) |=> (phase != PH_BEAT));
  // R4: every burst starts at beat zero
  a_r4_beat_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_BEAT) |=> (phase != PH_BEAT || cnt == '0));
  // R6: the recovery count never runs past its setting
  a_r6_recov_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECOV) |-> ({1'b0, cnt} < trwl_lim));
  // R2: the row-to-column wait never runs past its setting
  a_r2_trw_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRW) |-> ({1'b0, cnt} < trw_lim));
  // R7: precharge wait is one cycle and is followed by the done pulse
  a_r7_tpc_done: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TPC) |=> (done && phase == PH_IDLE));
endmodule

// File: rtl/slw_beat_mux.sv
module slw_beat_mux
  import slw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W*BEATS-1:0] line_q,
  input  logic [IDX_W-1:0]        base,
  input  logic [IDX_W-1:0]        beat,
  output logic [DATA_W-1:0]       word
);
  logic [DATA_W-1:0] words [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_word
    assign words[k] = line_q[k*DATA_W +: DATA_W];
  end

  assign word = words[wrap_idx(base, beat)];
endmodule

// File: rtl/slw_pin_drive.sv
module slw_pin_drive
  import slw_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic [IDX_W-1:0]  cnt,
  input  logic [BANK_W-1:0] bank_q,
  input  logic [ROW_W-1:0]  row_q,
  input  logic [COL_W-1:0]  col_q,
  input  logic [DATA_W-1:0] beat_word,
  output logic [3:0]        cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic [DATA_W/8-1:0] dqm,
  output logic [DATA_W-1:0] dq
);
  logic is_act;
  logic is_wr;
  logic in_beat;

  assign is_act  = (phase == PH_ACT);
  assign is_wr   = (phase == PH_BEAT) && (cnt == '0);
  assign in_beat = (phase == PH_BEAT);

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (is_act) begin
      cmd  = CMD_ACTV;
      ba   = bank_q;
      addr = row_q;
    end else if (is_wr) begin
      cmd  = CMD_WRITE;
      ba   = bank_q;
      addr[COL_W-1:0] = col_q;
      addr[AP_BIT]    = 1'b1;
    end
  end

  assign dqm = in_beat ? '0 : '1;
  assign dq  = in_beat ? beat_word : '0;

  // R3: every write requests auto-precharge
  a_r3_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE) |-> addr[AP_BIT]);
  // R4: bytes are unmasked only while data beats are on the bus
  a_r4_dqm_window: assert property (@(posedge clk) disable iff (!rst_n)
    (dqm != '1) |-> (phase == PH_BEAT && dqm == '0));
  // R2: the write follows an activate or a wait cycle, never anything else
  a_r2_write_after_row: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE) |-> ($past(phase) == PH_ACT || $past(phase) == PH_TRW));
  // R10: only the activate and write slots carry an address
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) |-> (addr == '0 && ba == '0));
endmodule

// File: rtl/sdram_line_writer.sv
module sdram_line_writer
  import slw_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int DATA_W = 32,
  localparam int LINE_W = DATA_W * BEATS,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [1:0]        trw_cfg_i,
  input  logic [2:0]        trwl_cfg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [MASK_W-1:0] dqm_o,
  output logic [DATA_W-1:0] dq_o
);
  phase_t            phase;
  logic [IDX_W-1:0]  cnt;
  logic              accept;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [LINE_W-1:0] line_q;
  logic [1:0]        trw_q;
  logic [2:0]        trwl_q;
  logic [DATA_W-1:0] beat_word;
  logic [3:0]        cmd;

  assign busy_o = (phase != PH_IDLE);
  assign accept = start_i && !busy_o;

  slw_req_hold #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .LINE_W(LINE_W)) u_hold (
    .clk, .rst_n, .load(accept), .start_i, .busy_i(busy_o),
    .bank_i, .row_i, .col_i, .line_i, .trw_i(trw_cfg_i), .trwl_i(trwl_cfg_i),
    .bank_q, .row_q, .col_q, .line_q, .trw_q, .trwl_q
  );

  slw_phase_fsm u_fsm (
    .clk, .rst_n, .accept, .trw_q, .trwl_q, .phase, .cnt, .done(done_o)
  );

  slw_beat_mux #(.DATA_W(DATA_W)) u_mux (
    .line_q, .base(col_q[IDX_W-1:0]), .beat(cnt), .word(beat_word)
  );

  slw_pin_drive #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
                  .AP_BIT(AP_BIT), .DATA_W(DATA_W)) u_pins (
    .clk, .rst_n, .phase, .cnt, .bank_q, .row_q, .col_q, .beat_word,
    .cmd, .ba(ba_o), .addr(addr_o), .dqm(dqm_o), .dq(dq_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

  // R7: done only ever appears with busy low
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R1: an accepted start is followed by the activate command
  a_r1_act_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd == CMD_ACTV && busy_o));
endmodule

// File: tb/sdram_line_writer_test.sv
module sdram_line_writer_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   bank_i = '0;
  logic [12:0]  row_i = '0;
  logic [9:0]   col_i = '0;
  logic [255:0] line_i = '0;
  logic [1:0]   trw_cfg_i = '0;
  logic [2:0]   trwl_cfg_i = '0;
  logic         busy_o, done_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [1:0]   ba_o;
  logic [12:0]  addr_o;
  logic [3:0]   dqm_o;
  logic [31:0]  dq_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  sdram_line_writer uut (
    .clk, .rst_n, .start_i, .bank_i, .row_i, .col_i, .line_i,
    .trw_cfg_i, .trwl_cfg_i, .busy_o, .done_o, .cs_n_o, .ras_n_o,
    .cas_n_o, .we_n_o, .ba_o, .addr_o, .dqm_o, .dq_o
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] word_of(input int seed, input int k);
    return (32'(seed) * 32'h9E3779B1) ^ (32'(k) * 32'h01010101) ^ 32'(k << 4);
  endfunction

  function automatic logic [255:0] make_line(input int seed);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = word_of(seed, k);
    return l;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input string ctx);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] t=%0t: actual=%h expected=%h", tag, ctx, $time, act, exp);
    end
  endtask

  // Runs one burst; must be called right after a falling edge.
  task automatic burst(input int n, input int m, input logic [1:0] bank,
                       input logic [12:0] row, input logic [9:0] col, input int seed,
                       input bit interfere, input string ctx);
    int last;
    logic [255:0] line;
    logic [3:0] ecmd;
    logic [1:0] eba;
    logic [12:0] eaddr;
    logic [3:0] edqm;
    logic [31:0] edq;
    string ctag;
    line = make_line(seed);
    bank_i = bank; row_i = row; col_i = col; line_i = line;
    trw_cfg_i = 2'(n); trwl_cfg_i = 3'(m); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // scramble inputs after acceptance: held values must be used (R2 R6 R8)
    bank_i = ~bank; row_i = ~row; col_i = col + 10'd3; line_i = ~line;
    trw_cfg_i = ~trw_cfg_i; trwl_cfg_i = ~trwl_cfg_i;
    last = 11 + n + m;
    for (int c = 1; c <= last; c++) begin
      int b;
      b = c - (2 + n);
      ecmd = 4'b0111; eba = '0; eaddr = '0; ctag = "R10";
      if (c == 1) begin
        ecmd = 4'b0011; eba = bank; eaddr = row; ctag = "R1";
      end else if (c == 2 + n) begin
        ecmd = 4'b0100; eba = bank; eaddr = {2'b00, 1'b1, col}; ctag = "R2 R3";
      end
      if (b >= 0 && b < 8) begin
        edqm = 4'h0;
        edq = word_of(seed, (int'(col[2:0]) + b) % 8);
      end else begin
        edqm = 4'hF;
        edq = '0;
      end
      if (interfere) ctag = {ctag, " R8"};
      check(ctag, 64'({cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o}),
                  64'({ecmd, eba, eaddr}), ctx);
      check(interfere ? "R4 R5 R8" : "R4 R5", 64'({dqm_o, dq_o}), 64'({edqm, edq}), ctx);
      check(interfere ? "R6 R7 R8" : "R6 R7", 64'({busy_o, done_o}),
            64'({c <= last - 1, c == last}), ctx);
      if (interfere && c == 4) begin
        start_i = 1'b1; bank_i = ~bank; row_i = row ^ 13'h155; col_i = col ^ 10'h2A5;
        line_i = make_line(seed + 77); trw_cfg_i = 2'(3 - n); trwl_cfg_i = 3'(7 - m);
      end
      if (c == 5) start_i = 1'b0;
      @(negedge clk);
    end
    check("R7", 64'({busy_o, done_o}), 64'b00, {ctx, " after done"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", 64'({busy_o, done_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, dqm_o, ba_o, addr_o}),
          64'({2'b00, 4'b0111, 4'hF, 2'b00, 13'h0}), "reset");
    check("R9", 64'(dq_o), 64'h0, "reset dq");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", 64'({busy_o, cs_n_o, ras_n_o, cas_n_o, we_n_o}), 64'b0_0111, "idle");
    // R2 R6: every wait / recovery combination
    for (int n = 0; n < 4; n++)
      for (int m = 0; m < 8; m++)
        burst(n, m, 2'(n ^ m), 13'(n * 911 + m * 37), 10'(m * 8 + n * 3 + 1),
              n * 8 + m, 1'b0, $sformatf("sweep trw=%0d trwl=%0d", n, m));
    // R5: every starting offset inside the line
    for (int o = 0; o < 8; o++)
      burst(1, 2, 2'(o), 13'h1ABC ^ 13'(o), 10'h3F8 | 10'(o), 100 + o, 1'b0,
            $sformatf("wrap offset=%0d", o));
    // R8: starts during busy bursts
    burst(0, 0, 2'd1, 13'h0F0F, 10'h005, 200, 1'b1, "busy start 0/0");
    burst(3, 7, 2'd2, 13'h1234, 10'h17E, 201, 1'b1, "busy start 3/7");
    // back-to-back acceptance right after done
    burst(2, 5, 2'd3, 13'h1FFF, 10'h3FF, 202, 1'b0, "max addresses");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule